// File: doc/BRIEF.md
# Pulse-Width Uplink Bit Decoder with Code Match

This block turns a squared, pulse-width-modulated envelope into data bits and flags when the latest bits form a fixed tag code. The sender sets the bit clock by the repetition rate of the envelope. Each bit period starts with a falling edge. The length of the low phase that follows carries the value: a short low (about a quarter of the period) is a 1, and a long low (about three quarters) is a 0. The receiver has no bit clock of its own. A fast local sampling clock counts the low phase and the full period. When the next falling edge closes the period, the block compares the two counts and decides the bit.

Each decoded bit goes out with a one-cycle strobe and also shifts into a short history register. When the history holds the configured code, oldest bit first, the block raises a one-cycle hit pulse on that strobe. The comparison uses the measured period, so the same instance decodes slow and fast senders without retuning. A silent or stuck envelope cannot overflow the counters. If the envelope has no falling edge for a whole timeout window, the history is cleared and decoding starts again from the next edge.

Top module: `pwm_uplink_matcher`

## Requirements
- R1: A bit whose low phase, counted in sampling cycles, is less than half of its full period (2*low < period) decodes as 1.
- R2: A bit whose low phase is half of its period or longer decodes as 0, including the exact half case.
- R3: The first falling edge after reset or after a timeout emits no strobe. Every later falling edge emits exactly one single-cycle strobe, and bit_o then carries the value of the bit that this edge closed.
- R4: Decoded bits enter the history at the LSB. hit_o asserts when the last CODE_W bits, oldest in the MSB, equal CODE (default 4'b0010, i.e. bits 0,0,1,0 in arrival order). It never asserts for any other pattern.
- R5: hit_o is a single-cycle pulse and is asserted only in the cycle where strobe_o is high.
- R6: hit_o requires at least CODE_W bits decoded since reset or since the last timeout. A cleared history never counts as a match.
- R7: When TIMEOUT_CYC sampling cycles pass with no falling edge, the history and its fill count are cleared. The bit in progress is dropped and the next falling edge only re-arms the decoder.
- R8: Decoding depends only on the ratio of low time to period, so bit periods of 60 and 170 sampling cycles (a ratio near 1200:420 bit/s) both decode correctly.
- R9: During and right after reset, bit_o, strobe_o and hit_o are 0.
- R10: The period and low counters saturate at their maximum. A stuck-low envelope produces no strobe, and decoding resumes correctly after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| env_i | input | 1 | Squared modulation envelope, asynchronous to clk_i |
| bit_o | output | 1 | Most recently decoded bit value |
| strobe_o | output | 1 | One-cycle pulse marking a new decoded bit |
| hit_o | output | 1 | One-cycle pulse when the history matches CODE |

## Verification
The bound checker watches every cycle for the following. A hit appears only together with a strobe, with a full history equal to the code. Strobes never come on two cycles in a row. A saturated period counter stays at its maximum until an edge arrives. A timeout empties the history. Other properties hold only across a whole stimulus and need the bench scenarios to show them: the value each bit decodes to, including the exact half-duty boundary; the silent first edge after re-arming; decoding at two very different periods; and recovery after a long stuck-low envelope.

// File: rtl/pwm_uplink_pkg.sv
package pwm_uplink_pkg;

  // One decoded event handed from the duty meter to the matcher.
  typedef struct packed {
    logic valid;
    logic value;
  } dec_evt_t;

  // 1 when the low phase is shorter than half of the period.
  function automatic logic short_low(input logic [32:0] low_len,
                                     input logic [32:0] period_len);
    return (low_len << 1) < period_len;
  endfunction

endpackage

// File: rtl/pwm_sync_chain.sv
module pwm_sync_chain #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_uplink_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned TIMEOUT_CYC = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             env_i,
  output dec_evt_t         evt_o,
  output logic             flush_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] period_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT_CYC);

  logic             env_prev_q, env_prev_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] low_q, low_d;
  logic             fall, timed_out;

  assign fall      = env_prev_q & ~env_i;
  assign timed_out = armed_q && (period_q >= TO_LIM);

  always_comb begin
    env_prev_d = env_i;
    period_d   = period_q;
    low_d      = low_q;
    armed_d    = armed_q;
    if (fall) begin
      period_d = CNT_W'(1);
      low_d    = CNT_W'(1);
    end else begin
      if (period_q != CNT_MAX)          period_d = period_q + 1'b1;
      if (!env_i && (low_q != CNT_MAX)) low_d    = low_q + 1'b1;
    end
    if (timed_out) armed_d = 1'b0;
    if (fall)      armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_prev_q <= 1'b1;
      armed_q    <= 1'b0;
      period_q   <= '0;
      low_q      <= '0;
    end else begin
      env_prev_q <= env_prev_d;
      armed_q    <= armed_d;
      period_q   <= period_d;
      low_q      <= low_d;
    end
  end

  assign evt_o.valid = fall && armed_q && !timed_out;
  assign evt_o.value = short_low(33'(low_q), 33'(period_q));
  assign flush_o     = timed_out;
  assign fall_o      = fall;
  assign period_o    = period_q;

endmodule

// File: rtl/pwm_code_matcher.sv
module pwm_code_matcher
  import pwm_uplink_pkg::*;
#(
  parameter int unsigned       CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE   = 4'b0010,
  localparam int unsigned      FILL_W = $clog2(CODE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dec_evt_t          evt_i,
  input  logic              flush_i,
  output logic              bit_o,
  output logic              strobe_o,
  output logic              hit_o,
  output logic [CODE_W-1:0] hist_o,
  output logic [FILL_W-1:0] fill_o
);

  localparam logic [FILL_W-1:0] FULL = FILL_W'(CODE_W);

  logic [CODE_W-1:0] hist_q, hist_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              bit_q, bit_d, bit_en;
  logic              strobe_q, strobe_d;
  logic              hit_q, hit_d;

  always_comb begin
    hist_d   = hist_q;
    fill_d   = fill_q;
    strobe_d = 1'b0;
    bit_en   = 1'b0;
    bit_d    = evt_i.value;
    if (flush_i) begin
      hist_d = '0;
      fill_d = '0;
    end else if (evt_i.valid) begin
      hist_d   = {hist_q[CODE_W-2:0], evt_i.value};
      fill_d   = (fill_q == FULL) ? fill_q : fill_q + 1'b1;
      strobe_d = 1'b1;
      bit_en   = 1'b1;
    end
    hit_d = strobe_d && (fill_d == FULL) && (hist_d == CODE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= '0;
      fill_q   <= '0;
      strobe_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      fill_q   <= fill_d;
      strobe_q <= strobe_d;
      hit_q    <= hit_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bit_q <= 1'b0;
    else if (bit_en) bit_q <= bit_d;
  end

  assign bit_o    = bit_q;
  assign strobe_o = strobe_q;
  assign hit_o    = hit_q;
  assign hist_o   = hist_q;
  assign fill_o   = fill_q;

endmodule

// File: rtl/pwm_uplink_matcher.sv
module pwm_uplink_matcher
  import pwm_uplink_pkg::*;
#(
  parameter int unsigned       CNT_W       = 12,
  parameter int unsigned       TIMEOUT_CYC = 3000,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       CODE_W      = 4,
  parameter logic [CODE_W-1:0] CODE        = 4'b0010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic env_i,
  output logic bit_o,
  output logic strobe_o,
  output logic hit_o
);

  localparam int unsigned FILL_W = $clog2(CODE_W + 1);

  logic              rst_n_sync;
  logic              env_sync;
  dec_evt_t          evt;
  logic              meas_flush;
  logic              meas_fall;
  logic [CNT_W-1:0]  meas_period;
  logic [CODE_W-1:0] match_hist;
  logic [FILL_W-1:0] match_fill;

  pwm_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_sync)
  );

  pwm_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_env_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .d_i   (env_i),
    .q_o   (env_sync)
  );

  pwm_duty_meter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .env_i   (env_sync),
    .evt_o   (evt),
    .flush_o (meas_flush),
    .fall_o  (meas_fall),
    .period_o(meas_period)
  );

  pwm_code_matcher #(.CODE_W(CODE_W), .CODE(CODE)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .evt_i   (evt),
    .flush_i (meas_flush),
    .bit_o   (bit_o),
    .strobe_o(strobe_o),
    .hit_o   (hit_o),
    .hist_o  (match_hist),
    .fill_o  (match_fill)
  );

endmodule

// File: rtl/pwm_uplink_checker.sv
module pwm_uplink_checker #(
  parameter int unsigned       CNT_W  = 12,
  parameter int unsigned       CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE   = 4'b0010,
  localparam int unsigned      FILL_W = $clog2(CODE_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_o,
  input logic              hit_o,
  input logic              fall_i,
  input logic              flush_i,
  input logic [CNT_W-1:0]  period_i,
  input logic [CODE_W-1:0] hist_i,
  input logic [FILL_W-1:0] fill_i
);

  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [FILL_W-1:0] FULL    = FILL_W'(CODE_W);

  assert_hit_on_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> strobe_o);

  assert_hit_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hist_i == CODE));

  assert_hit_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (fill_i == FULL));

  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == CNT_MAX && !fall_i) |=> (period_i == CNT_MAX));

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (fill_i == '0 && !strobe_o));

endmodule

bind pwm_uplink_matcher pwm_uplink_checker #(
  .CNT_W (CNT_W),
  .CODE_W(CODE_W),
  .CODE  (CODE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strobe_o(strobe_o),
  .hit_o   (hit_o),
  .fall_i  (meas_fall),
  .flush_i (meas_flush),
  .period_i(meas_period),
  .hist_i  (match_hist),
  .fill_i  (match_fill)
);

// File: tb/pwm_uplink_matcher_bench.sv
module pwm_uplink_matcher_bench;

  localparam int unsigned CNT_W   = 12;
  localparam int unsigned TIMEOUT = 1000;
  localparam logic [3:0]  CODE    = 4'b0010;
  localparam int          FAST_P  = 60;
  localparam int          SLOW_P  = 170;

  logic clk;
  logic rst_n;
  logic env;
  logic bit_o, strobe_o, hit_o;

  int n_tests;
  int n_fail;
  int hits_seen;
  int hits_exp;

  // bench model of the decoder
  logic [1:0] exp_q[$];
  logic [3:0] m_hist;
  int         m_fill;
  logic       m_armed;
  logic       m_prev;
  logic       mon_en;

  pwm_uplink_matcher #(
    .CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT), .CODE_W(4), .CODE(CODE)
  ) u_pwm_uplink_matcher (
    .clk_i(clk), .rst_ni(rst_n), .env_i(env),
    .bit_o(bit_o), .strobe_o(strobe_o), .hit_o(hit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Model of one falling edge on the envelope.
  task automatic fall_event();
    logic [1:0] e;
    if (m_armed) begin
      m_hist = {m_hist[2:0], m_prev};
      if (m_fill < 4) m_fill++;
      e = {(m_fill == 4) && (m_hist == CODE), m_prev};
      if (e[1]) hits_exp++;
      exp_q.push_back(e);
    end
    m_armed = 1'b1;
  endtask

  task automatic model_clear();
    m_armed = 1'b0;
    m_hist  = '0;
    m_fill  = 0;
  endtask

  task automatic send_raw(input int lo, input int hi, input logic b);
    fall_event();
    m_prev = b;
    env = 1'b0;
    cyc(lo);
    env = 1'b1;
    cyc(hi);
  endtask

  task automatic send_bit(input logic b, input int per);
    int lo;
    lo = b ? per / 4 : (3 * per) / 4;
    send_raw(lo, per - lo, b);
  endtask

  task automatic gap();
    env = 1'b1;
    cyc(TIMEOUT + 300);
    model_clear();
  endtask

  // Each strobe is compared with the next expected event.
  always @(negedge clk) begin
    if (mon_en) begin
      if (strobe_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected strobe", 1, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check(bit_o == e[0], e[0] ? "R1" : "R2", "decoded bit", bit_o, e[0]);
          check(hit_o == e[1], "R4", "hit flag", hit_o, e[1]);
          if (hit_o) hits_seen++;
        end
      end
      if (hit_o && !strobe_o) check(1'b0, "R5", "hit without strobe", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; hits_seen = 0; hits_exp = 0;
    mon_en = 1'b0;
    env = 1'b1;
    model_clear();
    m_prev = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'h1A2B3C4D));
    cyc(5);
    // R9: outputs quiet during reset
    check(!bit_o && !strobe_o && !hit_o, "R9", "outputs in reset",
          {bit_o, strobe_o, hit_o}, 0);
    rst_n = 1'b1;
    cyc(4);
    check(!bit_o && !strobe_o && !hit_o, "R9", "outputs after reset",
          {bit_o, strobe_o, hit_o}, 0);
    mon_en = 1'b1;

    // R4: directed match 0,0,1,0, closed by a trailing bit
    send_bit(0, FAST_P); send_bit(0, FAST_P); send_bit(1, FAST_P);
    send_bit(0, FAST_P); send_bit(1, FAST_P);
    // R1 / R2 boundary: exact half decodes 0, one cycle shorter decodes 1
    send_raw(40, 40, 1'b0);
    send_raw(39, 40, 1'b1);
    send_raw(41, 40, 1'b0);
    send_bit(0, FAST_P);

    // R7 / R6: timeout drops history; the 0,1,0 that follows gives no hit
    gap();
    send_bit(0, FAST_P); send_bit(1, FAST_P); send_bit(0, FAST_P);
    send_bit(1, FAST_P); send_bit(1, FAST_P);

    // R8: random streams at the fast and the slow rate
    for (int i = 0; i < 60; i++) send_bit(1'($urandom_range(1, 0)), FAST_P);
    gap();
    for (int i = 0; i < 60; i++) send_bit(1'($urandom_range(1, 0)), SLOW_P);
    // R8: directed match at the slow rate
    send_bit(0, SLOW_P); send_bit(0, SLOW_P); send_bit(1, SLOW_P);
    send_bit(0, SLOW_P); send_bit(0, SLOW_P);

    // R10: stuck-low envelope saturates the counters, no strobe beyond the edge event
    fall_event();
    env = 1'b0;
    cyc(5000);
    model_clear();
    env = 1'b1;
    cyc(30);
    send_bit(0, FAST_P); send_bit(0, FAST_P); send_bit(1, FAST_P);
    send_bit(0, FAST_P); send_bit(1, FAST_P);
    for (int i = 0; i < 40; i++) send_bit(1'($urandom_range(1, 0)), FAST_P);
    gap();
    cyc(20);

    // R3: every expected strobe was seen
    check(exp_q.size() == 0, "R3", "missing strobes", exp_q.size(), 0);
    // R4: hit count matches the model
    check(hits_seen == hits_exp, "R4", "hit count", hits_seen, hits_exp);
    check(hits_exp >= 3, "R4", "directed hits present", hits_exp, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule